// File: doc/BRIEF.md
# PWM Crossover and Output-Disable Stage

This block sits between a three-phase PWM generator and the gate-drive pins. It receives a high-side and a low-side PWM signal for each phase. For each phase pair it can exchange the two signals, so that the high-side wave drives the low pin and the low-side wave drives the high pin. After that exchange, it can hold any of the six pins at its inactive level. The outputs are active low, so the inactive (OFF) level is logic 1. A typical use is electronically commutated motor control. Software programs identical duty cycles on two channels, crosses one pair over, and disables the idle leg. It then rewrites the disable pattern as the rotor turns.

Software writes a 9-bit control word into a shadow register. The word that actually steers the outputs is a separate active copy. The active copy is loaded from the shadow on the rising edge of the cycle-sync pulse. In double-update mode it is also loaded on the rising edge of the mid-cycle pulse. The active copy therefore never changes part-way through a PWM half-cycle. A read returns the shadow value. The active value is brought out on a separate debug port.

Control word layout: bits 8, 7 and 6 are the crossover bits for phases 2, 1 and 0. Bits 5 down to 0 disable the pins 0H, 0L, 1H, 1L, 2H and 2L, in that order.

Top module: `pwm_xover_mask`

## Requirements
- R1: When crossover bit 6+p (p = 0, 1, 2) of the active word is 1, pin_hi[p] follows raw_lo[p] and pin_lo[p] follows raw_hi[p]. When the bit is 0, each pin follows its own raw signal.
- R2: Active-word bits 5,4,3,2,1,0 force pin_hi[0], pin_lo[0], pin_hi[1], pin_lo[1], pin_hi[2], pin_lo[2] respectively to 1 (OFF) while set, whatever the raw inputs.
- R3: The disable mask acts on pin positions after crossover. A disable bit names a pin, not a raw source.
- R4: After reset, the shadow word and the active word are both 0: no crossover, and all pins follow their raw inputs.
- R5: The active word takes the shadow value at a rising edge of sync_pulse (0 in the previous clock, 1 in this one). It is held in all clocks without a load.
- R6: With dbl_mode = 1, a rising edge of mid_pulse also loads the active word. With dbl_mode = 0, mid_pulse has no effect.
- R7: A write in the same clock as a sync rising edge is not loaded by that edge. It becomes active at the next load event.
- R8: rd_data always shows the last written (shadow) word. active_word shows the word currently steering the pins.
- R9: Holding sync_pulse high for several clocks loads only once, at its rising edge. Writes made while it stays high wait for the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shadow control word |
| wr_data | input | 9 | Control word to write |
| rd_data | output | 9 | Shadow control word |
| sync_pulse | input | 1 | PWM cycle-start sync |
| mid_pulse | input | 1 | PWM mid-cycle marker |
| dbl_mode | input | 1 | 1 = double-update mode |
| raw_hi | input | 3 | Raw high-side PWM, one bit per phase |
| raw_lo | input | 3 | Raw low-side PWM, one bit per phase |
| pin_hi | output | 3 | Conditioned high-side outputs (active low) |
| pin_lo | output | 3 | Conditioned low-side outputs (active low) |
| active_word | output | 9 | Debug view of the active control word |

## Verification
Assertions run on every cycle and cover four things:
- A set disable bit forces its pin to 1, and a crossed pair routes each raw signal to the opposite pin.
- The active word changes only on a qualifying edge, and takes the prior shadow value when it does.
- A mid-cycle edge in single-update mode leaves the active word unchanged.
- Reset clears both registers.

Some behaviour only the bench scenarios can show: the exact write-versus-sync ordering, the single load while sync is held high, the shadow read-back, and the pin mapping under many random waveforms. The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/pwm_xm_pkg.sv
// Package: shared helpers for the PWM crossover / disable stage.
// Assumes the control word is [crossover bits per phase | two disable bits per phase],
// with phase 0's disable bits at the top of the disable field.
package pwm_xm_pkg;

    // Disable-bit index of the high pin of phase p among n phases.
    function automatic int unsigned hi_bit(input int unsigned p, input int unsigned n);
        return 2 * (n - 1 - p) + 1;
    endfunction

    // Disable-bit index of the low pin of phase p among n phases.
    function automatic int unsigned lo_bit(input int unsigned p, input int unsigned n);
        return 2 * (n - 1 - p);
    endfunction

    // Crossover-bit index of phase p among n phases.
    function automatic int unsigned xo_bit(input int unsigned p, input int unsigned n);
        return 2 * n + p;
    endfunction

endpackage

// File: rtl/xm_ctrl_regs.sv
// Module: shadow and active control-word registers.
// The shadow takes software writes. The active copy loads from the shadow on a
// rising sync edge, or on a rising mid edge when double-update mode is on.
// Assumes sync/mid are synchronous to clk. A write in a load clock is seen
// only at the following load, because the load samples the pre-write shadow.
module xm_ctrl_regs #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         sync_pulse,
    input  logic         mid_pulse,
    input  logic         dbl_mode,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] active_q
);

    logic sync_d, mid_d;
    logic sync_rise, mid_rise, load_now;

    assign sync_rise = sync_pulse & ~sync_d;
    assign mid_rise  = mid_pulse & ~mid_d;
    assign load_now  = sync_rise | (dbl_mode & mid_rise);

    // Remember the previous sync/mid levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d <= 1'b0;
            mid_d  <= 1'b0;
        end else begin
            sync_d <= sync_pulse;
            mid_d  <= mid_pulse;
        end
    end

    // Capture software writes into the shadow word.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (wr_en) shadow_q <= wr_data;
    end

    // Copy the shadow into the active word on a load event.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_q <= '0;
        else if (load_now) active_q <= shadow_q;
    end

    // R4: reset clears both words.
    p_reset_clear_r4: assert property (@(posedge clk)
        !rst_n |=> (shadow_q == '0 && active_q == '0));

    // R5: without a load event the active word holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_rise || (dbl_mode && mid_rise)) |=> $stable(active_q));

    // R5/R7: a sync edge loads the pre-write shadow value.
    p_sync_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> active_q == $past(shadow_q));

    // R6: single-update mode ignores the mid-cycle edge.
    p_mid_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_mode && mid_rise && !sync_rise) |=> $stable(active_q));

endmodule

// File: rtl/xm_xover.sv
// Module: per-phase crossover multiplexer.
// Each phase pair swaps its high and low raw signals when its select bit is set.
// Purely combinational.
module xm_xover #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] swap,
    input  logic [N-1:0] in_hi,
    input  logic [N-1:0] in_lo,
    output logic [N-1:0] out_hi,
    output logic [N-1:0] out_lo
);

    for (genvar p = 0; p < N; p++) begin : g_pair
        // Route each raw signal to its own or the opposite pin.
        always_comb begin
            out_hi[p] = swap[p] ? in_lo[p] : in_hi[p];
            out_lo[p] = swap[p] ? in_hi[p] : in_lo[p];
        end

        // R1: a crossed pair exchanges its two sources.
        p_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
            swap[p] |-> (out_hi[p] == in_lo[p] && out_lo[p] == in_hi[p]));
    end

endmodule

// File: rtl/xm_out_mask.sv
// Module: per-pin forced-OFF mask.
// Drives a pin to the inactive level (1, since the outputs are active low)
// while its disable bit is set. Sits after the crossover, so the mask indexes
// final pin positions.
module xm_out_mask #(
    parameter int unsigned N = 3
) (
    input  logic [2*N-1:0] off_bits,
    input  logic [N-1:0]   in_hi,
    input  logic [N-1:0]   in_lo,
    output logic [N-1:0]   pin_hi,
    output logic [N-1:0]   pin_lo
);
    import pwm_xm_pkg::*;

    for (genvar p = 0; p < N; p++) begin : g_pin
        // Force the pin OFF when its disable bit is set.
        always_comb begin
            pin_hi[p] = off_bits[hi_bit(p, N)] ? 1'b1 : in_hi[p];
            pin_lo[p] = off_bits[lo_bit(p, N)] ? 1'b1 : in_lo[p];
        end
    end

endmodule

// File: rtl/pwm_xover_mask.sv
// Module: top of the PWM crossover / output-disable stage.
// Chain: shadow/active word registers -> per-pair crossover -> per-pin OFF mask.
// Assumes raw PWM inputs are synchronous to clk. The pin path is combinational
// from the raw inputs and the active word.
module pwm_xover_mask #(
    parameter int unsigned NUM_PH = 3,
    localparam int unsigned W     = 3 * NUM_PH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic              sync_pulse,
    input  logic              mid_pulse,
    input  logic              dbl_mode,
    input  logic [NUM_PH-1:0] raw_hi,
    input  logic [NUM_PH-1:0] raw_lo,
    output logic [NUM_PH-1:0] pin_hi,
    output logic [NUM_PH-1:0] pin_lo,
    output logic [W-1:0]      active_word
);
    import pwm_xm_pkg::*;

    logic [W-1:0]      shadow_q, active_q;
    logic [NUM_PH-1:0] x_hi, x_lo;

    xm_ctrl_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sync_pulse (sync_pulse),
        .mid_pulse  (mid_pulse),
        .dbl_mode   (dbl_mode),
        .shadow_q   (shadow_q),
        .active_q   (active_q)
    );

    xm_xover #(.N(NUM_PH)) u_xover (
        .clk    (clk),
        .rst_n  (rst_n),
        .swap   (active_q[W-1:2*NUM_PH]),
        .in_hi  (raw_hi),
        .in_lo  (raw_lo),
        .out_hi (x_hi),
        .out_lo (x_lo)
    );

    xm_out_mask #(.N(NUM_PH)) u_mask (
        .off_bits (active_q[2*NUM_PH-1:0]),
        .in_hi    (x_hi),
        .in_lo    (x_lo),
        .pin_hi   (pin_hi),
        .pin_lo   (pin_lo)
    );

    assign rd_data     = shadow_q;
    assign active_word = active_q;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_chk
        // R2/R3: a set disable bit holds its pin at OFF regardless of routing.
        p_off_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
            active_q[hi_bit(p, NUM_PH)] |-> pin_hi[p]);
        p_off_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
            active_q[lo_bit(p, NUM_PH)] |-> pin_lo[p]);
        // R1/R3: an enabled, crossed high pin shows the raw low signal.
        p_xo_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (active_q[xo_bit(p, NUM_PH)] && !active_q[hi_bit(p, NUM_PH)])
                |-> pin_hi[p] == raw_lo[p]);
    end

endmodule

// File: tb/pwm_xover_mask_tb.sv
// Bench: drives random and directed stimulus, keeps a behavioural model of the
// shadow/active words, and compares pins, active word and read-back every cycle.
module pwm_xover_mask_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int W  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          sync_pulse = 1'b0, mid_pulse = 1'b0, dbl_mode = 1'b0;
    logic [NP-1:0] raw_hi = '0, raw_lo = '0;
    logic [W-1:0]  rd_data, active_word;
    logic [NP-1:0] pin_hi, pin_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    pwm_xover_mask u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sync_pulse(sync_pulse), .mid_pulse(mid_pulse),
        .dbl_mode(dbl_mode), .raw_hi(raw_hi), .raw_lo(raw_lo),
        .pin_hi(pin_hi), .pin_lo(pin_lo), .active_word(active_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model of the two words.
    int m_shadow = 0, m_active = 0;
    bit m_sync_prev = 0, m_mid_prev = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_shadow <= 0; m_active <= 0; m_sync_prev <= 0; m_mid_prev <= 0;
        end else begin
            if (wr_en) m_shadow <= int'(wr_data);
            if ((sync_pulse && !m_sync_prev) || (dbl_mode && mid_pulse && !m_mid_prev))
                m_active <= m_shadow;
            m_sync_prev <= sync_pulse;
            m_mid_prev  <= mid_pulse;
        end
    end

    function automatic logic [2*NP-1:0] exp_pins(int act, logic [NP-1:0] h, logic [NP-1:0] l);
        logic [2*NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            logic eh, el;
            eh = h[p]; el = l[p];
            if (act[6+p]) begin eh = l[p]; el = h[p]; end
            if (act[5-2*p]) eh = 1'b1;
            if (act[4-2*p]) el = 1'b1;
            r[2*p+1] = eh; r[2*p] = el;
        end
        return r;
    endfunction

    task automatic check(string req, int act_v, int exp_v);
        n_checks++;
        if (act_v != exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    // Continuous comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2*NP-1:0] got;
            for (int p = 0; p < NP; p++) begin
                got[2*p+1] = pin_hi[p]; got[2*p] = pin_lo[p];
            end
            check("R1/R2/R3 pins", int'(got), int'(exp_pins(m_active, raw_hi, raw_lo)));
            check("R5/R6 active_word", int'(active_word), m_active);
            check("R8 rd_data", int'(rd_data), m_shadow);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [W-1:0] v);
        wr_en = 1'b1; wr_data = v; step(); wr_en = 1'b0;
    endtask

    task automatic sync_tick();
        sync_pulse = 1'b1; step(); sync_pulse = 1'b0; step();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R4: reset state.
        check("R4 active after reset", int'(active_word), 0);
        check("R4 shadow after reset", int'(rd_data), 0);
        raw_hi = 3'b010; raw_lo = 3'b101; #1;
        check("R4 pins follow raw", int'({pin_hi, pin_lo}), int'({3'b010, 3'b101}));

        // R8: write shows on read-back, not on active.
        wr(9'h0A7);
        check("R8 shadow read", int'(rd_data), 'h0A7);
        check("R5 not active before sync", int'(active_word), 0);
        sync_tick();
        check("R5 loaded at sync", int'(active_word), 'h0A7);

        // R1: phase-1 crossover only (bit 7): pin_hi[1] shows raw_lo[1].
        wr(9'h080); sync_tick();
        raw_hi = 3'b000; raw_lo = 3'b010; #1;
        check("R1 crossed hi", int'(pin_hi[1]), 1);
        check("R1 crossed lo", int'(pin_lo[1]), 0);

        // R3: crossover on phase 0 + disable 0H (bit 5): high pin OFF, low pin shows raw_hi.
        wr(9'h060); sync_tick();
        raw_hi = 3'b000; raw_lo = 3'b000; #1;
        check("R3 mask after crossover hi", int'(pin_hi[0]), 1);
        check("R3 crossed lo from raw_hi", int'(pin_lo[0]), 0);

        // R7: write in the same clock as a sync rising edge.
        wr_en = 1'b1; wr_data = 9'h003; sync_pulse = 1'b1; step();
        wr_en = 1'b0; sync_pulse = 1'b0; step();
        check("R7 same-clock write not loaded", int'(active_word), 'h060);
        sync_tick();
        check("R7 loaded at next sync", int'(active_word), 'h003);

        // R6: mid ignored in single mode, used in double mode.
        wr(9'h1C0);
        mid_pulse = 1'b1; step(); mid_pulse = 1'b0; step();
        check("R6 mid ignored single", int'(active_word), 'h003);
        dbl_mode = 1'b1;
        mid_pulse = 1'b1; step(); mid_pulse = 1'b0; step();
        check("R6 mid loads double", int'(active_word), 'h1C0);
        dbl_mode = 1'b0;

        // R9: held sync loads once only.
        sync_pulse = 1'b1; step();
        wr(9'h015); step(2);
        check("R9 held sync no reload", int'(active_word), 'h1C0);
        sync_pulse = 1'b0; step();
        sync_tick();
        check("R9 next edge loads", int'(active_word), 'h015);

        // Random phase, checked every cycle by the model.
        for (int c = 0; c < 3000; c++) begin
            raw_hi = NP'($urandom); raw_lo = NP'($urandom);
            wr_en = ($urandom % 8) == 0; wr_data = W'($urandom);
            sync_pulse = (c % 16) < ((c / 512) % 2 + 1);
            mid_pulse  = (c % 16) == 8;
            dbl_mode   = ((c / 256) % 2) == 1;
            step();
        end
        wr_en = 1'b0;
        step(2);
        done = 1'b1;
        report();
    end
endmodule